// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block is the architectural register storage of a small 16-bit processor core. It keeps two complete banks of seven banked registers (four data registers R0 to R3, two address registers A0 and A1, and a frame base FB). Outside the banks it keeps the registers that both banks share:
- a 20-bit program counter;
- a 20-bit interrupt vector base;
- a user stack pointer and an interrupt stack pointer;
- a static base register;
- a 16-bit flag word.

Two read ports are purely combinational. One write port commits on the rising clock edge. A separate flag-load port lets the execution unit deposit freshly computed flags.

Every access carries a 4-bit selector and a 2-bit width code. Only certain combinations are allowed. R0 and R1 may be accessed as single bytes. R0 and R1 also name the 32-bit pairs (R2:R0 and R3:R1). The program counter and the vector base are reached as 20-bit quantities in a 32-bit container. The bank used by every banked access is chosen by a bit of the stored flag word. A generic stack-pointer selector resolves to one of the two physical stack pointers through another flag bit.

All ports are plain control and data pins. Reads are combinational and writes commit in a single cycle, so the block never stalls. It has no valid/ready handshake and applies no back-pressure.

Top module: `cpu_regbank`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every register in both banks, all shared registers and the flag word. After reset, bank 0 is active and the generic stack pointer maps to the interrupt stack pointer.
- R2: Selector codes are: R0=0, R1=1, R2=2, R3=3, A0=4, A1=5, FB=6, PC=7, vector-base upper=8, vector-base lower=9, user SP=10, interrupt SP=11, generic SP=12, static base=13, flags=14, full vector base=15. Width codes are: 0 low byte, 1 high byte, 2 16-bit, 3 32-bit. The legal combinations are:
  - byte widths with selectors 0 and 1 only;
  - 16-bit width with every selector except 7 and 15;
  - 32-bit width with selectors 0, 1, 7 and 15.
  An illegal read raises that port's error output and returns zero. An illegal write, when `wr_en` is high, raises `wr_err` and changes no register.
- R3: A byte write takes its data from `wr_data[7:0]` and updates only the addressed half of R0 or R1; the other half is unchanged. A byte read returns the addressed half zero-extended in bits 7:0.
- R4: A 32-bit access with selector 0 treats R2 as bits 31:16 and R0 as bits 15:0. Selector 1 does the same with R3 and R1. A 32-bit write updates both registers in the same edge.
- R5: Flag bit 4 selects the bank (0 or 1) used by every banked read and write. The other bank keeps its contents unchanged.
- R6: Flag bit 7 maps the generic stack pointer (selector 12) to the user stack pointer when 1 and to the interrupt stack pointer when 0. This applies to both reads and writes.
- R7: The program counter and the full vector base are 20 bits wide. A 32-bit write stores `wr_data[19:0]`, and a 32-bit read returns the value zero-extended. Selector 8 reads and writes vector-base bits 19:16 through data bits 3:0. Selector 9 reads and writes vector-base bits 15:0.
- R8: The flag word places its fields as follows:
  - carry at bit 0, debug at bit 1, zero at bit 2, sign at bit 3;
  - bank at bit 4, overflow at bit 5, interrupt enable at bit 6, stack select at bit 7;
  - interrupt priority level at bits 14:12.
  The remaining bits always read as zero regardless of what is written.
- R9: When `flg_we` is high, the flag word loads `flg_wdata` at the edge. A legal main-port write to selector 14 in the same cycle takes precedence over the flag-load port.
- R10: When the flag word changes in the same cycle as a banked or generic-SP write, that write uses the bank and stack-pointer choice that held before the edge.
- R11: The two read ports are independent and combinational. Each reflects the state after the most recent edge, with its own selector and width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_sel | input | 4 | Read port A selector |
| rd_a_wid | input | 2 | Read port A width code |
| rd_a_data | output | 32 | Read port A data, zero-extended |
| rd_a_err | output | 1 | Read port A illegal combination |
| rd_b_sel | input | 4 | Read port B selector |
| rd_b_wid | input | 2 | Read port B width code |
| rd_b_data | output | 32 | Read port B data, zero-extended |
| rd_b_err | output | 1 | Read port B illegal combination |
| wr_en | input | 1 | Write request for this cycle |
| wr_sel | input | 4 | Write selector |
| wr_wid | input | 2 | Write width code |
| wr_data | input | 32 | Write data |
| wr_err | output | 1 | Write request is an illegal combination |
| flg_we | input | 1 | Flag-load strobe from the execution unit |
| flg_wdata | input | 16 | Flag value to load |
| flags_o | output | 16 | Stored flag word |

## Verification
The hardest case to reach from the ports is a flag change in the same cycle as a banked or stack-pointer write. The write must land in the previously active bank or stack pointer, and this only shows up after the bank is switched back. The bench creates this case with directed sequences: a flag-load pulse is paired with an A0 write, and a flag-word write through the flag port is paired with a generic-SP write. The bench then flips the selection back and reads the hidden register. Long random runs add frequent flag loads with random bank and stack bits. These runs mix byte, pair and illegal accesses, and a bench model compares every read port and error output.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
  localparam int WORD_W    = 16;
  localparam int HALF_W    = WORD_W / 2;
  localparam int LONG_W    = 2 * WORD_W;
  localparam int ADDR_W    = 20;
  localparam int ADDR_HI_W = ADDR_W - WORD_W;
  localparam int BANK_REGS = 7;
  localparam int NUM_BANKS = 2;
  localparam int PAIR_OFS  = 2;

  localparam int FB_BANK = 4;
  localparam int FB_USPS = 7;
  localparam logic [WORD_W-1:0] FLG_MASK = 16'h70FF;

  typedef enum logic [1:0] {W_LO = 2'd0, W_HI = 2'd1, W_WORD = 2'd2, W_LONG = 2'd3} wid_e;

  typedef enum logic [3:0] {
    S_R0 = 4'd0, S_R1 = 4'd1, S_R2 = 4'd2, S_R3 = 4'd3,
    S_A0 = 4'd4, S_A1 = 4'd5, S_FB = 4'd6, S_PC = 4'd7,
    S_VBH = 4'd8, S_VBL = 4'd9, S_USP = 4'd10, S_ISP = 4'd11,
    S_SP = 4'd12, S_SB = 4'd13, S_FLG = 4'd14, S_VB = 4'd15
  } sel_e;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [BANK_REGS-1:0] bank_t;

  function automatic logic access_ok(input sel_e s, input wid_e w);
    case (w)
      W_LO, W_HI: return (s == S_R0) || (s == S_R1);
      W_WORD:     return (s != S_PC) && (s != S_VB);
      default:    return (s == S_R0) || (s == S_R1) || (s == S_PC) || (s == S_VB);
    endcase
  endfunction
endpackage

// File: rtl/rbank_store.sv
module rbank_store
  import rbank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [BANK_REGS-1:0] we_lo,
  input  logic [BANK_REGS-1:0] we_hi,
  input  bank_t                wval,
  output bank_t                regs
);
  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < BANK_REGS; i++) begin
        if (we_lo[i]) regs[i][HALF_W-1:0]      <= wval[i][HALF_W-1:0];
        if (we_hi[i]) regs[i][WORD_W-1:HALF_W] <= wval[i][WORD_W-1:HALF_W];
      end
    end
  end
endmodule

// File: rtl/rbank_rdport.sv
module rbank_rdport
  import rbank_pkg::*;
(
  input  bank_t             act,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] vbase,
  input  word_t             usp,
  input  word_t             isp,
  input  word_t             sb,
  input  word_t             flg,
  input  logic [3:0]        sel,
  input  logic [1:0]        wid,
  output logic [LONG_W-1:0] data,
  output logic              err
);
  sel_e  s;
  wid_e  w;
  word_t bw;
  word_t pw;

  assign s = sel_e'(sel);
  assign w = wid_e'(wid);

  always_comb begin
    bw = '0;
    pw = '0;
    for (int i = 0; i < BANK_REGS; i++) begin
      if (int'(sel) == i) bw = act[i];
      if (int'(sel) + PAIR_OFS == i) pw = act[i];
    end
  end

  always_comb begin
    data = '0;
    err  = 1'b0;
    if (!access_ok(s, w)) begin
      err = 1'b1;
    end else begin
      case (s)
        S_R0, S_R1: begin
          case (w)
            W_LO:    data = LONG_W'(bw[HALF_W-1:0]);
            W_HI:    data = LONG_W'(bw[WORD_W-1:HALF_W]);
            W_WORD:  data = LONG_W'(bw);
            default: data = {pw, bw};
          endcase
        end
        S_R2, S_R3, S_A0, S_A1, S_FB: data = LONG_W'(bw);
        S_PC:    data = LONG_W'(pc);
        S_VB:    data = LONG_W'(vbase);
        S_VBH:   data = LONG_W'(vbase[ADDR_W-1:WORD_W]);
        S_VBL:   data = LONG_W'(vbase[WORD_W-1:0]);
        S_USP:   data = LONG_W'(usp);
        S_ISP:   data = LONG_W'(isp);
        S_SP:    data = LONG_W'(flg[FB_USPS] ? usp : isp);
        S_SB:    data = LONG_W'(sb);
        default: data = LONG_W'(flg);
      endcase
    end
  end
endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
  import rbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  rd_a_sel,
  input  logic [1:0]  rd_a_wid,
  output logic [31:0] rd_a_data,
  output logic        rd_a_err,
  input  logic [3:0]  rd_b_sel,
  input  logic [1:0]  rd_b_wid,
  output logic [31:0] rd_b_data,
  output logic        rd_b_err,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [1:0]  wr_wid,
  input  logic [31:0] wr_data,
  output logic        wr_err,
  input  logic        flg_we,
  input  logic [15:0] flg_wdata,
  output logic [15:0] flags_o
);
  localparam int NRD = 2;

  word_t             flg_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] vb_q;
  word_t             usp_q;
  word_t             isp_q;
  word_t             sb_q;

  logic bsel;
  logic usel;
  sel_e ws;
  wid_e ww;
  logic wr_ok;

  assign bsel  = flg_q[FB_BANK];
  assign usel  = flg_q[FB_USPS];
  assign ws    = sel_e'(wr_sel);
  assign ww    = wid_e'(wr_wid);
  assign wr_ok = wr_en && access_ok(ws, ww);
  assign wr_err = wr_en && !wr_ok;
  assign flags_o = flg_q;

  // banked write decode, bank chosen by flags before this edge
  logic [BANK_REGS-1:0] we_lo;
  logic [BANK_REGS-1:0] we_hi;
  bank_t                wval;

  always_comb begin
    we_lo = '0;
    we_hi = '0;
    wval  = '0;
    for (int i = 0; i < BANK_REGS; i++) begin
      if (wr_ok && int'(wr_sel) == i) begin
        case (ww)
          W_LO: begin
            we_lo[i] = 1'b1;
            wval[i]  = {2{wr_data[HALF_W-1:0]}};
          end
          W_HI: begin
            we_hi[i] = 1'b1;
            wval[i]  = {2{wr_data[HALF_W-1:0]}};
          end
          default: begin
            we_lo[i] = 1'b1;
            we_hi[i] = 1'b1;
            wval[i]  = wr_data[WORD_W-1:0];
          end
        endcase
      end
      if (wr_ok && ww == W_LONG && int'(wr_sel) + PAIR_OFS == i) begin
        we_lo[i] = 1'b1;
        we_hi[i] = 1'b1;
        wval[i]  = wr_data[LONG_W-1:WORD_W];
      end
    end
  end

  bank_t bregs [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (int'(bsel) == b);
    rbank_store u_store (
      .clk   (clk),
      .rst   (rst),
      .we_lo (we_lo & {BANK_REGS{hit}}),
      .we_hi (we_hi & {BANK_REGS{hit}}),
      .wval  (wval),
      .regs  (bregs[b])
    );
  end

  bank_t act;
  assign act = bregs[bsel];

  // shared registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      vb_q  <= '0;
      usp_q <= '0;
      isp_q <= '0;
      sb_q  <= '0;
    end else if (wr_ok) begin
      case (ws)
        S_PC:  pc_q <= wr_data[ADDR_W-1:0];
        S_VB:  vb_q <= wr_data[ADDR_W-1:0];
        S_VBH: vb_q[ADDR_W-1:WORD_W] <= wr_data[ADDR_HI_W-1:0];
        S_VBL: vb_q[WORD_W-1:0] <= wr_data[WORD_W-1:0];
        S_USP: usp_q <= wr_data[WORD_W-1:0];
        S_ISP: isp_q <= wr_data[WORD_W-1:0];
        S_SP: begin
          if (usel) usp_q <= wr_data[WORD_W-1:0];
          else      isp_q <= wr_data[WORD_W-1:0];
        end
        S_SB:  sb_q <= wr_data[WORD_W-1:0];
        default: ;
      endcase
    end
  end

  // flag word: main port beats the flag-load port
  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q <= '0;
    end else if (wr_ok && ws == S_FLG) begin
      flg_q <= wr_data[WORD_W-1:0] & FLG_MASK;
    end else if (flg_we) begin
      flg_q <= flg_wdata & FLG_MASK;
    end
  end

  // read ports
  logic [3:0]        rsel  [NRD];
  logic [1:0]        rwid  [NRD];
  logic [LONG_W-1:0] rdata [NRD];
  logic              rerr  [NRD];

  assign rsel[0] = rd_a_sel;
  assign rwid[0] = rd_a_wid;
  assign rsel[1] = rd_b_sel;
  assign rwid[1] = rd_b_wid;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rbank_rdport u_rd (
      .act   (act),
      .pc    (pc_q),
      .vbase (vb_q),
      .usp   (usp_q),
      .isp   (isp_q),
      .sb    (sb_q),
      .flg   (flg_q),
      .sel   (rsel[p]),
      .wid   (rwid[p]),
      .data  (rdata[p]),
      .err   (rerr[p])
    );
  end

  assign rd_a_data = rdata[0];
  assign rd_a_err  = rerr[0];
  assign rd_b_data = rdata[1];
  assign rd_b_err  = rerr[1];
endmodule

// File: rtl/rbank_chk.sv
module rbank_chk
  import rbank_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [3:0]  rd_a_sel,
  input logic [1:0]  rd_a_wid,
  input logic [31:0] rd_a_data,
  input logic        rd_a_err,
  input logic [3:0]  rd_b_sel,
  input logic [1:0]  rd_b_wid,
  input logic [31:0] rd_b_data,
  input logic        rd_b_err,
  input logic        wr_en,
  input logic [3:0]  wr_sel,
  input logic [1:0]  wr_wid,
  input logic [31:0] wr_data,
  input logic        wr_err,
  input logic        flg_we,
  input logic [15:0] flg_wdata,
  input logic [15:0] flags_o
);
  logic main_flg;
  assign main_flg = wr_en && !wr_err && (wr_sel == S_FLG);

  // R1
  reset_clears_flags_chk: assert property (@(posedge clk) rst |=> (flags_o == '0));

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_o & ~FLG_MASK) == '0);

  // R2
  rd_a_err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_a_err |-> (rd_a_data == '0));

  // R2
  rd_b_err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_b_err |-> (rd_b_data == '0));

  // R2
  wr_err_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> wr_en);

  // R2
  wr_err_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_err && !flg_we) |=> $stable(flags_o));

  // R9
  flag_port_load_chk: assert property (@(posedge clk) disable iff (rst)
    (flg_we && !main_flg) |=> (flags_o == ($past(flg_wdata) & FLG_MASK)));

  // R9
  main_port_wins_chk: assert property (@(posedge clk) disable iff (rst)
    main_flg |=> (flags_o == ($past(wr_data[15:0]) & FLG_MASK)));
endmodule

bind cpu_regbank rbank_chk u_rbank_chk (.*);

// File: tb/tb_cpu_regbank.sv
module tb_cpu_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rd_a_sel, rd_b_sel, wr_sel;
  logic [1:0]  rd_a_wid, rd_b_wid, wr_wid;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        rd_a_err, rd_b_err, wr_en, wr_err, flg_we;
  logic [15:0] flg_wdata, flags_o;

  cpu_regbank dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model
  logic [15:0] mb [2][7];
  logic [19:0] m_pc, m_vb;
  logic [15:0] m_usp, m_isp, m_sb, m_flg;

  function automatic bit m_ok(input logic [3:0] s, input logic [1:0] w);
    if (w < 2) return s < 2;
    if (w == 2) return !(s == 7 || s == 15);
    return s == 0 || s == 1 || s == 7 || s == 15;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] s, input logic [1:0] w);
    int b = int'(m_flg[4]);
    if (!m_ok(s, w)) return 32'h0;
    if (s < 7) begin
      if (w == 0) return {24'h0, mb[b][s][7:0]};
      if (w == 1) return {24'h0, mb[b][s][15:8]};
      if (w == 3) return {mb[b][s+2], mb[b][s]};
      return {16'h0, mb[b][s]};
    end
    case (s)
      7:  return {12'h0, m_pc};
      8:  return {28'h0, m_vb[19:16]};
      9:  return {16'h0, m_vb[15:0]};
      10: return {16'h0, m_usp};
      11: return {16'h0, m_isp};
      12: return {16'h0, m_flg[7] ? m_usp : m_isp};
      13: return {16'h0, m_sb};
      14: return {16'h0, m_flg};
      default: return {12'h0, m_vb};
    endcase
  endfunction

  task automatic m_reset();
    for (int b = 0; b < 2; b++) for (int i = 0; i < 7; i++) mb[b][i] = '0;
    m_pc = '0; m_vb = '0; m_usp = '0; m_isp = '0; m_sb = '0; m_flg = '0;
  endtask

  task automatic m_write(input bit we, input logic [3:0] s, input logic [1:0] w,
                         input logic [31:0] d, input bit fwe, input logic [15:0] fd);
    int b = int'(m_flg[4]);
    bit u = m_flg[7];
    bit ok = we && m_ok(s, w);
    if (ok) begin
      if (s < 7) begin
        if (w == 0) mb[b][s][7:0] = d[7:0];
        else if (w == 1) mb[b][s][15:8] = d[7:0];
        else mb[b][s] = d[15:0];
        if (w == 3) mb[b][s+2] = d[31:16];
      end else begin
        case (s)
          7:  m_pc = d[19:0];
          8:  m_vb[19:16] = d[3:0];
          9:  m_vb[15:0] = d[15:0];
          10: m_usp = d[15:0];
          11: m_isp = d[15:0];
          12: if (u) m_usp = d[15:0]; else m_isp = d[15:0];
          13: m_sb = d[15:0];
          15: m_vb = d[19:0];
          default: ;
        endcase
      end
    end
    if (ok && s == 14) m_flg = d[15:0] & 16'h70FF;
    else if (fwe) m_flg = fd & 16'h70FF;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, clock, update model
  task automatic step(input string req, input bit we, input logic [3:0] s, input logic [1:0] w,
                      input logic [31:0] d, input bit fwe, input logic [15:0] fd,
                      input logic [3:0] ra, input logic [1:0] wa,
                      input logic [3:0] rb, input logic [1:0] wb);
    wr_en = we; wr_sel = s; wr_wid = w; wr_data = d;
    flg_we = fwe; flg_wdata = fd;
    rd_a_sel = ra; rd_a_wid = wa; rd_b_sel = rb; rd_b_wid = wb;
    #1;
    chk({req, " R11 port A data"}, rd_a_data, m_read(ra, wa));
    chk({req, " R2 port A err"}, {31'h0, rd_a_err}, {31'h0, !m_ok(ra, wa)});
    chk({req, " R11 port B data"}, rd_b_data, m_read(rb, wb));
    chk({req, " R2 port B err"}, {31'h0, rd_b_err}, {31'h0, !m_ok(rb, wb)});
    chk({req, " R2 wr_err"}, {31'h0, wr_err}, {31'h0, we && !m_ok(s, w)});
    chk({req, " R8 flags"}, {16'h0, flags_o}, {16'h0, m_flg});
    @(posedge clk);
    m_write(we, s, w, d, fwe, fd);
    @(negedge clk);
  endtask

  task automatic wr(input string req, input logic [3:0] s, input logic [1:0] w, input logic [31:0] d);
    step(req, 1'b1, s, w, d, 1'b0, 16'h0, 4'd0, 2'd2, 4'd14, 2'd2);
  endtask

  task automatic look(input string req, input logic [3:0] s, input logic [1:0] w, input logic [31:0] exp);
    wr_en = 1'b0; flg_we = 1'b0;
    rd_a_sel = s; rd_a_wid = w;
    #1;
    chk(req, rd_a_data, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; wr_en = 0; wr_sel = 0; wr_wid = 0; wr_data = 0;
    flg_we = 0; flg_wdata = 0;
    rd_a_sel = 0; rd_a_wid = 2; rd_b_sel = 0; rd_b_wid = 2;
    m_reset();
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd0; wr_wid = 2'd2; wr_data = 32'hFFFF;
    flg_we = 1'b1; flg_wdata = 16'hFFFF;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0; flg_we = 1'b0;

    // R1 reset state
    look("R1 flags after reset", 4'd14, 2'd2, 32'h0);
    look("R1 R0 after reset", 4'd0, 2'd2, 32'h0);
    wr("R1", 4'd11, 2'd2, 32'h1234);
    look("R1 R6 SP maps to ISP after reset", 4'd12, 2'd2, 32'h1234);

    // R3 byte halves
    wr("R3", 4'd0, 2'd2, 32'hA1B2);
    wr("R3", 4'd0, 2'd0, 32'hFF33);
    look("R3 low byte write keeps high", 4'd0, 2'd2, 32'hA133);
    wr("R3", 4'd0, 2'd1, 32'h0044);
    look("R3 high byte write keeps low", 4'd0, 2'd2, 32'h4433);
    look("R3 high byte read", 4'd0, 2'd1, 32'h44);

    // R4 pairs
    wr("R4", 4'd1, 2'd3, 32'hDEADBEEF);
    look("R4 R1 low part", 4'd1, 2'd2, 32'hBEEF);
    look("R4 R3 high part", 4'd3, 2'd2, 32'hDEAD);
    look("R4 R2R0 read", 4'd0, 2'd3, 32'h00004433);

    // R2 illegal accesses
    wr("R2", 4'd2, 2'd0, 32'h55);
    look("R2 byte to R2 writes nothing", 4'd2, 2'd2, 32'h0);
    wr("R2", 4'd4, 2'd3, 32'h12345678);
    look("R2 long to A0 writes nothing", 4'd4, 2'd2, 32'h0);
    wr("R2", 4'd7, 2'd2, 32'h9);
    look("R2 word to PC writes nothing", 4'd7, 2'd3, 32'h0);

    // R7 wide registers
    wr("R7", 4'd7, 2'd3, 32'hFFFFFFFF);
    look("R7 PC 20 bits", 4'd7, 2'd3, 32'h000FFFFF);
    wr("R7", 4'd9, 2'd2, 32'hCAFE);
    wr("R7", 4'd8, 2'd2, 32'hFFF5);
    look("R7 vector base halves", 4'd15, 2'd3, 32'h0005CAFE);

    // R5 bank select
    wr("R5", 4'd14, 2'd2, 32'h0010);
    look("R5 bank1 R0 empty", 4'd0, 2'd2, 32'h0);
    wr("R5", 4'd0, 2'd2, 32'h5555);
    wr("R5", 4'd14, 2'd2, 32'h0000);
    look("R5 bank0 R0 kept", 4'd0, 2'd2, 32'h4433);

    // R10 same-cycle flag change and banked write
    step("R10", 1'b1, 4'd4, 2'd2, 32'h7777, 1'b1, 16'h0010, 4'd4, 2'd2, 4'd14, 2'd2);
    look("R10 new bank A0 untouched", 4'd4, 2'd2, 32'h0);
    wr("R10", 4'd14, 2'd2, 32'h0000);
    look("R10 old bank got A0", 4'd4, 2'd2, 32'h7777);
    step("R10", 1'b1, 4'd12, 2'd2, 32'h0BAD, 1'b1, 16'h0080, 4'd12, 2'd2, 4'd10, 2'd2);
    look("R10 R6 SP write went to ISP", 4'd11, 2'd2, 32'h0BAD);
    look("R6 SP now reads USP", 4'd12, 2'd2, 32'h0);

    // R6 SP through USP
    wr("R6", 4'd12, 2'd2, 32'h0C0C);
    look("R6 USP written through SP", 4'd10, 2'd2, 32'h0C0C);

    // R8 reserved bits
    wr("R8", 4'd14, 2'd2, 32'hFFFF);
    look("R8 reserved bits zero", 4'd14, 2'd2, 32'h70FF);

    // R9 main beats flag port
    step("R9", 1'b1, 4'd14, 2'd2, 32'h0001, 1'b1, 16'h0004, 4'd14, 2'd2, 4'd0, 2'd2);
    look("R9 main port wins", 4'd14, 2'd2, 32'h0001);
    step("R9", 1'b0, 4'd0, 2'd2, 32'h0, 1'b1, 16'h3008, 4'd14, 2'd2, 4'd0, 2'd2);
    look("R9 flag port load", 4'd14, 2'd2, 32'h3008);

    // random mix
    for (int k = 0; k < N_RAND; k++) begin
      bit we = ($urandom % 4) != 0;
      bit fwe = ($urandom % 8) == 0;
      step("random", we, 4'($urandom), 2'($urandom), $urandom, fwe, 16'($urandom),
           4'($urandom), 2'($urandom), 4'($urandom), 2'($urandom));
    end

    // R1 reset again clears both banks
    rst = 1'b1;
    @(posedge clk);
    m_reset();
    @(negedge clk);
    rst = 1'b0;
    look("R1 second reset flags", 4'd14, 2'd2, 32'h0);
    look("R1 second reset R3R1", 4'd1, 2'd3, 32'h0);
    look("R1 second reset PC", 4'd7, 2'd3, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule